// File: doc/BRIEF.md
# Transmit Descriptor Chain Fetcher

This block is the transmit-side list walker of an Ethernet-style DMA. Software builds a ring of two-word descriptors in memory, loads the ring's start address into the queue base register and issues a start command. The block then works through the ring one descriptor at a time. For each descriptor it fetches the described buffer through a 32-bit word memory port and sends the bytes out on a byte stream. The stream marks the first byte of each frame and the final byte of the frame's closing buffer.

When a frame closes, the block takes its first descriptor back from hardware by writing that descriptor's ownership flag. It then raises a sticky completion flag. Walking stops when the block fetches a descriptor that is already owned. If that happens partway through a frame, or if software turns transmit off mid-frame, the error is written into the frame's first descriptor and also shown in the status register. Framing, padding and CRC belong to the downstream MAC.

Top module: `txd_chain`

## Requirements
- R1: After reset the control and status registers read 0, no memory request is issued and the byte stream is idle.
- R2: Register port: reg_sel 0 is control, 1 is status and 2 is queue base. In control, bit 3 (transmit enable) and bit 2 (receive enable) read back as written. Bit 9 (start) always reads 0. A start write whose own bit 3 is 0 does nothing. A start write while busy is ignored.
- R3: Descriptor word 0 holds the buffer byte address. Word 1 holds: bit 31 owned-by-software, bit 30 wrap, bit 28 underrun, bit 27 exhausted, bit 15 last buffer, bits 10:0 length. Word 1 is fetched first. If it is owned at a frame boundary, the walk ends with no write and no completion.
- R4: Buffer bytes go out in ascending address order from any byte offset. Within a word, the lowest byte lane comes first. A byte advances only when tx_valid and tx_ready are both high, and it holds while tx_ready is low.
- R5: tx_sof marks the first byte of a frame. tx_eof marks the final byte of the buffer whose last bit is set. A frame may span several buffers.
- R6: When a frame completes, word 1 of the frame's first descriptor is rewritten with bit 31 set and bits 28 and 27 cleared, and its other bits are kept. Status bit 5 (done) is then set. The frame's other descriptors are not written.
- R7: The descriptor after one with the wrap bit set is fetched from the queue base. Otherwise the next descriptor is 8 bytes further on.
- R8: An owned descriptor met mid-frame ends the walk. The first descriptor gets bits 31 and 27 set and status bit 4 is set. No tx_eof and no done result.
- R9: Clearing control bit 3 while busy stops the walk. If a frame was in progress, the first descriptor gets bits 31 and 28 set and status bit 6 is set.
- R10: Status bits 4, 5 and 6 are cleared by writing 1 to them. Bit 3 reads 1 while busy and is read-only. A hardware set in the same cycle as a clear of the same bit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 queue base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (descriptor write-back) |
| mem_addr | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Final byte of a frame |

## Verification
Two events can land on the done flag in the same cycle: the hardware sets it during the write-back cycle, and software may issue a write-one-to-clear of bit 5 in that same cycle. The bench watches the memory port for the write strobe and drives the status clear exactly in that cycle. It then expects done to read 1, and to read 0 only after a second, separate clear. A halt arriving while a byte is stalled is also covered, and it must leave no byte delivered and an underrun mark in the frame's first descriptor.

// File: rtl/txd_chain.sv
module txd_chain #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof
);
  localparam int D_OWN = 31, D_WRAP = 30, D_UNDR = 28, D_EXH = 27, D_LAST = 15;
  localparam int C_GO = 9, C_TXEN = 3, C_RXEN = 2;
  localparam int S_UNDR = 6, S_DONE = 5, S_EXH = 4, S_BUSY = 3;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] W1   = ADDR_W'(4);

  typedef enum logic [3:0] {IDLE, RD_ST, WT_ST, RD_AD, WT_AD, RD_BUF, WT_BUF, STRM, WB} st_t;
  typedef enum logic [1:0] {K_DONE, K_EXH, K_UNDR} kind_t;

  st_t   st;
  kind_t kind;
  logic  tx_en, rx_en, done_q, exh_q, undr_q;
  logic  in_frame, sof_pend;
  logic [ADDR_W-1:0] qbase, ptr, first_ptr, buf_addr;
  logic [31:0]       first_stat, cur_stat, word_q;
  logic [LEN_W-1:0]  remain;

  logic busy, wr_ctrl, wr_stat, go, halt, last_byte;
  logic [ADDR_W-1:0] nxt_ptr;
  logic [31:0] wb_word;
  st_t  end_st;

  assign busy      = st != IDLE;
  assign wr_ctrl   = reg_wr && reg_sel == 2'd0;
  assign wr_stat   = reg_wr && reg_sel == 2'd1;
  assign go        = wr_ctrl && reg_wdata[C_GO] && reg_wdata[C_TXEN] && !busy;
  assign halt      = busy && !tx_en && st != WB;
  assign last_byte = remain == LEN_W'(1);
  assign nxt_ptr   = cur_stat[D_WRAP] ? qbase : ptr + STEP;
  assign end_st    = cur_stat[D_LAST] ? WB : RD_ST;

  always_comb begin
    wb_word = first_stat;
    wb_word[D_UNDR] = kind == K_UNDR;
    wb_word[D_EXH]  = kind == K_EXH;
    wb_word[D_OWN]  = 1'b1;
  end

  assign tx_valid = st == STRM && tx_en;
  assign tx_data  = 8'(word_q >> {buf_addr[1:0], 3'b000});
  assign tx_sof   = tx_valid && sof_pend;
  assign tx_eof   = tx_valid && last_byte && cur_stat[D_LAST];

  assign mem_req   = st == RD_ST || st == RD_AD || st == RD_BUF || st == WB;
  assign mem_we    = st == WB;
  assign mem_wdata = mem_we ? wb_word : 32'd0;

  always_comb begin
    case (st)
      RD_ST:   mem_addr = ptr + W1;
      RD_AD:   mem_addr = ptr;
      RD_BUF:  mem_addr = {buf_addr[ADDR_W-1:2], 2'b00};
      WB:      mem_addr = first_ptr + W1;
      default: mem_addr = '0;
    endcase
  end

  always_comb begin
    reg_rdata = 32'd0;
    case (reg_sel)
      2'd0: begin
        reg_rdata[C_TXEN] = tx_en;
        reg_rdata[C_RXEN] = rx_en;
      end
      2'd1: begin
        reg_rdata[S_UNDR] = undr_q;
        reg_rdata[S_DONE] = done_q;
        reg_rdata[S_EXH]  = exh_q;
        reg_rdata[S_BUSY] = busy;
      end
      2'd2: reg_rdata = 32'(qbase);
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
      qbase  <= '0;
      done_q <= 1'b0;
      exh_q  <= 1'b0;
      undr_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        tx_en <= reg_wdata[C_TXEN];
        rx_en <= reg_wdata[C_RXEN];
      end
      if (reg_wr && reg_sel == 2'd2) qbase <= reg_wdata[ADDR_W-1:0];
      done_q <= (st == WB && kind == K_DONE) || (done_q && !(wr_stat && reg_wdata[S_DONE]));
      exh_q  <= (st == WB && kind == K_EXH)  || (exh_q  && !(wr_stat && reg_wdata[S_EXH]));
      undr_q <= (st == WB && kind == K_UNDR) || (undr_q && !(wr_stat && reg_wdata[S_UNDR]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      kind       <= K_DONE;
      in_frame   <= 1'b0;
      sof_pend   <= 1'b0;
      ptr        <= '0;
      first_ptr  <= '0;
      buf_addr   <= '0;
      first_stat <= '0;
      cur_stat   <= '0;
      word_q     <= '0;
      remain     <= '0;
    end else if (halt) begin
      kind <= K_UNDR;
      st   <= in_frame ? WB : IDLE;
    end else begin
      case (st)
        IDLE: if (go) begin
          ptr      <= qbase;
          in_frame <= 1'b0;
          st       <= RD_ST;
        end
        RD_ST: st <= WT_ST;
        WT_ST: begin
          if (mem_rdata[D_OWN]) begin
            kind <= K_EXH;
            st   <= in_frame ? WB : IDLE;
          end else begin
            cur_stat <= mem_rdata;
            if (!in_frame) begin
              first_ptr  <= ptr;
              first_stat <= mem_rdata;
              in_frame   <= 1'b1;
              sof_pend   <= 1'b1;
            end
            st <= RD_AD;
          end
        end
        RD_AD: st <= WT_AD;
        WT_AD: begin
          buf_addr <= mem_rdata[ADDR_W-1:0];
          remain   <= cur_stat[LEN_W-1:0];
          if (cur_stat[LEN_W-1:0] == '0) begin
            kind <= K_DONE;
            st   <= end_st;
            if (!cur_stat[D_LAST]) ptr <= nxt_ptr;
          end else begin
            st <= RD_BUF;
          end
        end
        RD_BUF: st <= WT_BUF;
        WT_BUF: begin
          word_q <= mem_rdata;
          st     <= STRM;
        end
        STRM: if (tx_ready) begin
          buf_addr <= buf_addr + ADDR_W'(1);
          remain   <= remain - LEN_W'(1);
          sof_pend <= 1'b0;
          if (last_byte) begin
            kind <= K_DONE;
            st   <= end_st;
            if (!cur_stat[D_LAST]) ptr <= nxt_ptr;
          end else if (buf_addr[1:0] == 2'd3) begin
            st <= RD_BUF;
          end
        end
        WB: begin
          in_frame <= 1'b0;
          if (kind == K_DONE) begin
            ptr <= nxt_ptr;
            st  <= RD_ST;
          end else begin
            st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata, cur_stat};
endmodule

// File: rtl/txd_chain_chk.sv
module txd_chain_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        tx_en,
  input logic        done_bit,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_sof,
  input logic        tx_eof,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_valid));

  a_r2_go_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == 2'd0 |-> !reg_rdata[9]);

  a_r4_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!tx_en || (tx_valid && $stable(tx_data))));

  a_r5_markers_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof || tx_eof) |-> tx_valid);

  a_r6_wb_owned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && mem_wdata[31]));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_bit && !(reg_wr && reg_sel == 2'd1 && reg_wdata[5])) |=> done_bit);
endmodule

bind txd_chain txd_chain_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tx_en(tx_en), .done_bit(done_q),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_sof(tx_sof), .tx_eof(tx_eof), .mem_req(mem_req), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/txd_chain_bench.sv
`timescale 1ns/1ps
module txd_chain_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic        tx_valid, tx_sof, tx_eof;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;

  txd_chain u_txd_chain (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof)
  );

  logic [31:0] mem [0:255];
  always @(posedge clk)
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end

  int errors = 0;
  int checks = 0;
  int cap_n = 0;
  int req_cnt = 0;
  int tick = 0;
  int ready_mode = 0;
  logic [7:0] cap_d [0:255];
  logic       cap_s [0:255];
  logic       cap_e [0:255];
  logic [7:0] exp_b [0:63];
  int exp_n;

  always @(negedge clk) begin
    if (mem_req) req_cnt++;
    if (tx_valid && tx_ready) begin
      cap_d[cap_n & 255] = tx_data;
      cap_s[cap_n & 255] = tx_sof;
      cap_e[cap_n & 255] = tx_eof;
      cap_n++;
    end
    tick++;
    case (ready_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = tick[0];
      default: tx_ready = 1'b0;
    endcase
  end

  // {backpressure, buffer address, length}
  localparam logic [31:0] VEC [4] = '{32'h00010001, 32'h01010105, 32'h00020308, 32'h0103020D};

  function automatic logic [7:0] eb(input int a);
    logic [9:0] x;
    x = a[9:0];
    return x[7:0] ^ {x[9:8], 6'h15};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd_reg(2'd1, v);
      if (!v[3]) break;
    end
  endtask

  task automatic add_exp(input int a, input int n);
    for (int k = 0; k < n; k++) begin
      exp_b[exp_n] = eb(a + k);
      exp_n++;
    end
  endtask

  task automatic chk_bytes(input int base, input string req);
    int bad;
    bad = 0;
    for (int k = 0; k < exp_n; k++)
      if (cap_d[(base + k) & 255] !== exp_b[k]) bad++;
    chk(cap_n - base == exp_n, req, 32'(cap_n - base), 32'(exp_n));
    chk(bad == 0, req, 32'(bad), 32'd0);
  endtask

  logic [31:0] v;
  int base;

  initial begin
    for (int w = 64; w < 256; w++)
      mem[w] = {eb(w*4+3), eb(w*4+2), eb(w*4+1), eb(w*4)};
    for (int w = 0; w < 64; w++) mem[w] = 32'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_reg(2'd0, v); chk(v == 32'd0, "R1 ctrl", v, 32'd0);
    rd_reg(2'd1, v); chk(v == 32'd0, "R1 status", v, 32'd0);
    chk(!tx_valid && !mem_req, "R1 quiet", {30'd0, tx_valid, mem_req}, 32'd0);
    rst_n = 1'b1;

    // R2 enables read back, start with tx disabled does nothing
    wr_reg(2'd0, 32'h4);
    rd_reg(2'd0, v); chk(v == 32'h4, "R2 readback", v, 32'h4);
    base = req_cnt;
    wr_reg(2'd0, 32'h200);
    repeat (5) @(negedge clk);
    chk(req_cnt == base, "R2 go without enable", 32'(req_cnt - base), 32'd0);

    // R3 owned head descriptor: one fetch, no done; R2 start bit reads 0
    mem[1] = 32'h8000_0000;
    wr_reg(2'd2, 32'h0);
    base = req_cnt;
    wr_reg(2'd0, 32'h20C);
    wait_idle();
    rd_reg(2'd0, v); chk(v == 32'hC, "R2 start bit reads 0", v, 32'hC);
    chk(req_cnt - base == 1, "R3 single fetch", 32'(req_cnt - base), 32'd1);
    rd_reg(2'd1, v); chk(v[5] == 1'b0, "R3 no done", v, 32'd0);

    // R4 R5 R6 table of single-buffer frames
    foreach (VEC[i]) begin
      logic [31:0] orig;
      orig = 32'(VEC[i][7:0]) | 32'h8000 | ((i % 2 == 1) ? 32'h1800_0000 : 32'h0);
      mem[0] = 32'(VEC[i][23:8]);
      mem[1] = orig;
      mem[3] = 32'h8000_0000;
      ready_mode = int'(VEC[i][31:24]);
      exp_n = 0;
      add_exp(int'(VEC[i][23:8]), int'(VEC[i][7:0]));
      @(negedge clk); #1 base = cap_n;
      wr_reg(2'd0, 32'h208);
      wait_idle();
      chk_bytes(base, "R4 stream");
      chk(cap_s[base & 255] && cap_e[(base + exp_n - 1) & 255], "R5 markers", 32'(i), 32'd1);
      chk(mem[1] == ((orig & 32'hE7FF_FFFF) | 32'h8000_0000), "R6 writeback", mem[1],
          (orig & 32'hE7FF_FFFF) | 32'h8000_0000);
      rd_reg(2'd1, v); chk(v[5], "R6 done", v, 32'h20);
      wr_reg(2'd1, 32'h20);
    end
    ready_mode = 0;

    // R7 wrap, multi-buffer frame
    mem[16] = 32'h110; mem[17] = 32'h3;
    mem[18] = 32'h121; mem[19] = 32'h4000_8002;
    mem[20] = 32'h130; mem[21] = 32'h8001;
    mem[23] = 32'h8000_0000;
    wr_reg(2'd2, 32'h40);
    exp_n = 0; add_exp(32'h110, 3); add_exp(32'h121, 2);
    @(negedge clk); #1 base = cap_n;
    wr_reg(2'd0, 32'h208);
    wait_idle();
    chk_bytes(base, "R7 wrap stops at base");
    chk(cap_s[base & 255] && !cap_s[(base+3) & 255] && !cap_e[(base+2) & 255] && cap_e[(base+4) & 255],
        "R5 spanning markers", 32'd0, 32'd1);
    chk(mem[17] == 32'h8000_0003, "R6 first desc owned", mem[17], 32'h8000_0003);
    chk(mem[19] == 32'h4000_8002, "R6 later desc untouched", mem[19], 32'h4000_8002);
    wr_reg(2'd1, 32'h20);

    // R5 R6 two frames back to back
    mem[24] = 32'h160; mem[25] = 32'h8002;
    mem[26] = 32'h170; mem[27] = 32'h8001;
    mem[29] = 32'h8000_0000;
    wr_reg(2'd2, 32'h60);
    exp_n = 0; add_exp(32'h160, 2); add_exp(32'h170, 1);
    @(negedge clk); #1 base = cap_n;
    wr_reg(2'd0, 32'h208);
    wait_idle();
    chk_bytes(base, "R5 two frames");
    chk(cap_s[base & 255] && cap_e[(base+1) & 255] && cap_s[(base+2) & 255] && cap_e[(base+2) & 255],
        "R5 per-frame markers", 32'd0, 32'd1);
    chk(mem[25] == 32'h8000_8002 && mem[27] == 32'h8000_8001, "R6 both owned", mem[27], 32'h8000_8001);
    wr_reg(2'd1, 32'h20);

    // R8 exhausted mid-frame
    mem[32] = 32'h180; mem[33] = 32'h2;
    mem[35] = 32'h8000_0000;
    wr_reg(2'd2, 32'h80);
    exp_n = 0; add_exp(32'h180, 2);
    @(negedge clk); #1 base = cap_n;
    wr_reg(2'd0, 32'h208);
    wait_idle();
    chk_bytes(base, "R8 partial bytes");
    chk(!cap_e[base & 255] && !cap_e[(base+1) & 255], "R8 no eof", 32'd0, 32'd0);
    chk(mem[33] == 32'h8800_0002, "R8 desc mark", mem[33], 32'h8800_0002);
    rd_reg(2'd1, v); chk((v & 32'h70) == 32'h10, "R8 status", v & 32'h70, 32'h10);

    // R9 halt while a byte is stalled
    mem[40] = 32'h1A0; mem[41] = 32'h8028;
    wr_reg(2'd2, 32'hA0);
    ready_mode = 2;
    @(negedge clk); #1 base = cap_n;
    wr_reg(2'd0, 32'h208);
    repeat (20) @(negedge clk);
    wr_reg(2'd0, 32'h0);
    wait_idle();
    ready_mode = 0;
    chk(cap_n == base, "R9 no byte", 32'(cap_n - base), 32'd0);
    chk(mem[41] == 32'h9000_8028, "R9 desc mark", mem[41], 32'h9000_8028);
    rd_reg(2'd1, v); chk((v & 32'h78) == 32'h50, "R9 status", v & 32'h78, 32'h50);

    // R10 write-one-to-clear per bit
    wr_reg(2'd1, 32'h10);
    rd_reg(2'd1, v); chk((v & 32'h78) == 32'h40, "R10 clear exh only", v, 32'h40);
    wr_reg(2'd1, 32'h40);
    rd_reg(2'd1, v); chk(v == 32'h0, "R10 clear undr", v, 32'h0);

    // R10 set wins over a clear in the same cycle
    mem[48] = 32'h1C0; mem[49] = 32'h8001;
    mem[51] = 32'h8000_0000;
    wr_reg(2'd2, 32'hC0);
    wr_reg(2'd0, 32'h208);
    do @(negedge clk); while (!mem_we);
    reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h20;
    @(negedge clk);
    reg_wr = 1'b0;
    wait_idle();
    rd_reg(2'd1, v); chk(v[5], "R10 set wins", v, 32'h20);
    wr_reg(2'd1, 32'h20);
    rd_reg(2'd1, v); chk(!v[5], "R10 later clear", v, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule